// File: doc/BRIEF.md
# Interrupt-Held Serial Status Readout

This block is the slave side of a small serial readout link. It lets a host microcontroller fetch two values that are produced inside the chip. The first is a 4-bit status word, which the producer offers once per burst. The second is an 8-bit signal-to-noise byte. An internal counter offers that byte on every 128th data-bit strobe, and the count includes overhead bits. Each value has its own holding register and its own active-low interrupt. When a value is captured, its interrupt goes low. While that interrupt is pending, the holding register is frozen and any further offers for it are discarded.

To read a value, the host drives a register address, pulls chip select low and toggles a serial clock. The bits come out MSB first, and each new bit appears after a falling edge of the serial clock. Afterwards the host raises the latch strobe, which clears the interrupt of the register currently addressed. All host-side pins are brought into the system clock through synchronisers, so each host action takes effect about three system clocks after the pin changes.

The serial data pin has a separate output enable, which the pad ring uses to build the tri-state driver. The block has no general reset. The one exception is that the status word cannot be captured while the status reset input is low.

Top module: `ssr_readout_port`

## Requirements
- R1: At power-up both interrupt outputs are high (inactive) and `sdo_oe` is low.
- R2: A `stat_offer` pulse with no status interrupt pending and `rst2_n` high captures `stat_in` and drives `irq_stat_n` low.
- R3: While a register's interrupt is pending, new offers for that register are dropped and not queued, so the held value does not change.
- R4: A rising edge on `host_latch` while the address is 0 clears only `irq_stat_n`. While the address is 1, it clears only `irq_snr_n`.
- R5: The S/N byte is offered on every 128th `bit_tick` counted from power-up, taking the value of `snr_in` present with that tick.
- R6: Data leaves MSB first. A status read is 4 bits and an S/N read is 8 bits. The first bit is on `sdo` once chip select has fallen, and each falling edge of `host_sclk` advances one bit.
- R7: `sdo_oe` is high only while `host_cs_n` is low and the address is 0 or 1.
- R8: While `rst2_n` is low the status word is not captured. The S/N path and the serial readout keep working regardless of `rst2_n`.
- R9: A latch rising edge while the address is neither 0 nor 1 leaves both interrupts unchanged.
- R10: Every falling edge of chip select with address 0 or 1 reloads the shifter from the held value, so repeated reads return the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst2_n | input | 1 | Active-low reset that blocks status capture only |
| stat_offer | input | 1 | One-cycle offer of a new status word |
| stat_in | input | STAT_W | Status word offered |
| bit_tick | input | 1 | One-cycle strobe per data bit, overhead bits included |
| snr_in | input | SNR_W | Current S/N estimate |
| host_addr | input | ADDR_W | Register address from host (0 status, 1 S/N) |
| host_cs_n | input | 1 | Active-low chip select from host |
| host_sclk | input | 1 | Serial clock from host |
| host_latch | input | 1 | Interrupt clear strobe, rising edge acts |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| irq_stat_n | output | 1 | Active-low status interrupt |
| irq_snr_n | output | 1 | Active-low S/N interrupt |

## Verification
A lock flag stuck low would let a second offer overwrite the held word. This shows up on the very next read as a value that differs from the first capture. A missed or wrong clear leaves an interrupt output low about three clocks after the latch edge, when it should have gone high. A miscount in the bit counter moves the S/N interrupt away from the 128th tick, so the interrupt is visibly early or late on that tick. A fault in the shifter order corrupts the bit sequence from the first serial clock onward.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   localparam int ADDR_STAT = 0;
   localparam int ADDR_SNR  = 1;

   typedef enum logic [1:0] {SEL_NONE, SEL_STAT, SEL_SNR} sel_e;

   function automatic sel_e decode_sel(input logic [31:0] a);
      if (a == 32'(ADDR_STAT))     return SEL_STAT;
      else if (a == 32'(ADDR_SNR)) return SEL_SNR;
      else                         return SEL_NONE;
   endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
   parameter int         W      = 1,
   parameter int         STAGES = 2,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ssr_sync needs at least two stages");
   end

   logic [W-1:0] st [STAGES] = '{default: INIT};

   always_ff @(posedge clk) begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/ssr_capture.sv
module ssr_capture #(
   parameter int W     = 4,
   parameter bit GATED = 1'b0
) (
   input  logic         clk,
   input  logic         gate_n,
   input  logic         offer,
   input  logic [W-1:0] val,
   input  logic         clr,
   output logic [W-1:0] hold,
   output logic         irq
);
   localparam bit IGNORE_GATE = !GATED;

   logic [W-1:0] hold_r = '0;
   logic         irq_r  = 1'b0;
   logic         take;

   assign take = offer & ~irq_r & (gate_n | IGNORE_GATE);

   always_ff @(posedge clk) begin
      if (take) begin
         hold_r <= val;
         irq_r  <= 1'b1;
      end else if (clr) begin
         irq_r  <= 1'b0;
      end
   end

   assign hold = hold_r;
   assign irq  = irq_r;

   AST_IRQ_ON_LOAD: assert property (@(posedge clk) disable iff (!gate_n)
      (offer && !irq) |=> irq); // R2
   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!gate_n)
      irq |=> $stable(hold)); // R3
   AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!gate_n)
      (irq && clr) |=> !irq); // R4
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         shift,
   output logic         msb
);
   logic [W-1:0] sh = '0;

   always_ff @(posedge clk) begin
      if (load)       sh <= ld_val;
      else if (shift) sh <= {sh[W-2:0], 1'b0};
   end

   assign msb = sh[W-1];
endmodule

// File: rtl/ssr_readout_port.sv
module ssr_readout_port
   import ssr_pkg::*;
#(
   parameter int STAT_W      = 4,
   parameter int SNR_W       = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SNR_PERIOD  = 128
) (
   input  logic              clk,
   input  logic              rst2_n,
   input  logic              stat_offer,
   input  logic [STAT_W-1:0] stat_in,
   input  logic              bit_tick,
   input  logic [SNR_W-1:0]  snr_in,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_cs_n,
   input  logic              host_sclk,
   input  logic              host_latch,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              irq_stat_n,
   output logic              irq_snr_n
);
   localparam int HB_W  = ADDR_W + 3;
   localparam int CNT_W = (SNR_PERIOD > 2) ? $clog2(SNR_PERIOD) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SNR_PERIOD - 1);
   localparam logic [HB_W-1:0]  HB_INIT  = {ADDR_W'(0), 1'b1, 1'b0, 1'b0};

   if (STAT_W > SNR_W) begin : g_bad_width
      $error("status word wider than S/N shifter");
   end
   if (SNR_PERIOD < 2) begin : g_bad_period
      $error("S/N period must be at least two bits");
   end
   if (STAT_W < 1 || SNR_W < 2) begin : g_bad_small
      $error("register widths too small");
   end

   // host pins into the system clock domain
   logic [HB_W-1:0]   hb_s;
   logic [ADDR_W-1:0] addr_s;
   logic              cs_s, sclk_s, latch_s;

   ssr_sync #(.W(HB_W), .STAGES(SYNC_STAGES), .INIT(HB_INIT)) u_sync (
      .clk (clk),
      .d   ({host_addr, host_cs_n, host_sclk, host_latch}),
      .q   (hb_s)
   );
   assign {addr_s, cs_s, sclk_s, latch_s} = hb_s;

   logic cs_q = 1'b1, sclk_q = 1'b0, latch_q = 1'b0;
   always_ff @(posedge clk) begin
      cs_q    <= cs_s;
      sclk_q  <= sclk_s;
      latch_q <= latch_s;
   end

   sel_e sel;
   logic cs_fall, sclk_fall, latch_rise;
   assign sel        = decode_sel(32'(addr_s));
   assign cs_fall    = cs_q & ~cs_s;
   assign sclk_fall  = sclk_q & ~sclk_s & ~cs_s;
   assign latch_rise = latch_s & ~latch_q;

   // S/N offer cadence
   logic [CNT_W-1:0] bit_cnt = '0;
   logic             snr_offer;
   assign snr_offer = bit_tick && (bit_cnt == CNT_LAST);
   always_ff @(posedge clk) begin
      if (bit_tick) bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
   end

   // capture registers
   logic [STAT_W-1:0] stat_hold;
   logic [SNR_W-1:0]  snr_hold;
   logic              stat_irq, snr_irq;

   ssr_capture #(.W(STAT_W), .GATED(1'b1)) u_stat (
      .clk    (clk),
      .gate_n (rst2_n),
      .offer  (stat_offer),
      .val    (stat_in),
      .clr    (latch_rise && sel == SEL_STAT),
      .hold   (stat_hold),
      .irq    (stat_irq)
   );

   ssr_capture #(.W(SNR_W), .GATED(1'b0)) u_snr (
      .clk    (clk),
      .gate_n (1'b1),
      .offer  (snr_offer),
      .val    (snr_in),
      .clr    (latch_rise && sel == SEL_SNR),
      .hold   (snr_hold),
      .irq    (snr_irq)
   );

   // serial shift-out
   logic             sh_load;
   logic [SNR_W-1:0] sh_val;
   assign sh_load = cs_fall && (sel != SEL_NONE);
   assign sh_val  = (sel == SEL_STAT) ? (SNR_W'(stat_hold) << (SNR_W - STAT_W)) : snr_hold;

   ssr_shifter #(.W(SNR_W)) u_shift (
      .clk    (clk),
      .load   (sh_load),
      .ld_val (sh_val),
      .shift  (sclk_fall),
      .msb    (sdo)
   );

   assign sdo_oe     = ~cs_s & (sel != SEL_NONE);
   assign irq_stat_n = ~stat_irq;
   assign irq_snr_n  = ~snr_irq;

   AST_NO_STAT_IN_RST: assert property (@(posedge clk)
      !rst2_n |=> $stable(stat_hold)); // R8
   AST_FIRST_BIT_MSB: assert property (@(posedge clk) disable iff (!rst2_n)
      sh_load |=> (sdo == $past(sh_val[SNR_W-1]))); // R6
   AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst2_n)
      sdo_oe |-> !cs_s); // R7
endmodule

// File: tb/sim_ssr_readout_port.sv
module sim_ssr_readout_port;
   logic       clk = 1'b0;
   logic       rst2_n = 1'b0;
   logic       stat_offer = 1'b0;
   logic [3:0] stat_in = '0;
   logic       bit_tick = 1'b0;
   logic [7:0] snr_in = '0;
   logic [3:0] host_addr = 4'hF;
   logic       host_cs_n = 1'b1, host_sclk = 1'b0, host_latch = 1'b0;
   logic       sdo, sdo_oe, irq_stat_n, irq_snr_n;

   int total = 0, bad = 0, tick_cnt = 0;
   bit done = 0;
   logic [3:0] exp_stat = '0;
   logic [7:0] exp_snr = '0;
   bit stat_pend = 0, snr_pend = 0;

   always #10 clk = ~clk;

   ssr_readout_port u0 (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic offer_stat(input logic [3:0] v);
      @(negedge clk); stat_offer = 1; stat_in = v;
      @(negedge clk); stat_offer = 0;
      if (!stat_pend && rst2_n) begin exp_stat = v; stat_pend = 1; end
   endtask

   task automatic tick(input logic [7:0] v);
      @(negedge clk); bit_tick = 1; snr_in = v;
      @(negedge clk); bit_tick = 0;
      if (tick_cnt == 127 && !snr_pend) begin exp_snr = v; snr_pend = 1; end
      tick_cnt = (tick_cnt + 1) % 128;
   endtask

   function automatic int width_of(input int a);
      return (a == 0) ? 4 : 8;
   endfunction

   // read without clearing
   task automatic shift_in(input logic [3:0] a, output logic [7:0] val);
      int n = width_of(a);
      host_addr = a; waitn(4);
      host_cs_n = 0; waitn(5);
      check("R7 oe on valid read", sdo_oe, 1);
      val = '0;
      for (int i = 0; i < n; i++) begin
         val = {val[6:0], sdo};
         host_sclk = 1; waitn(4);
         host_sclk = 0; waitn(5);
      end
      host_cs_n = 1; waitn(5);
   endtask

   task automatic pulse_latch(input logic [3:0] a);
      host_addr = a; waitn(4);
      host_latch = 1; waitn(5);
      host_latch = 0; waitn(5);
      host_addr = 4'hF; waitn(4);
      if (a == 0) stat_pend = 0;
      if (a == 1) snr_pend = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      void'($urandom(32'd7));
      waitn(3);
      check("R1 irq_stat_n idle", irq_stat_n, 1);
      check("R1 irq_snr_n idle", irq_snr_n, 1);
      check("R1 oe idle", sdo_oe, 0);
      rst2_n = 1; waitn(2);

      // R2 capture and R6 MSB-first 4-bit read
      offer_stat(4'hB); waitn(1);
      check("R2 irq_stat_n low", irq_stat_n, 0);
      offer_stat(4'h4); // R3 dropped
      shift_in(0, rd);
      check("R6 status bits", rd, 32'hB);
      check("R3 status held", rd, exp_stat);
      shift_in(0, rd);
      check("R10 reread status", rd, 32'hB);

      // R7 other address keeps output off
      host_addr = 4'h2; waitn(4); host_cs_n = 0; waitn(5);
      check("R7 oe off addr 2", sdo_oe, 0);
      host_cs_n = 1; host_addr = 4'hF; waitn(5);

      // R5 S/N cadence
      for (int i = 0; i < 127; i++) tick(8'(i));
      check("R5 no snr before 128th", irq_snr_n, 1);
      tick(8'hA5); waitn(1);
      check("R5 snr irq on 128th", irq_snr_n, 0);
      for (int i = 0; i < 128; i++) tick(8'h3C); // R3 dropped
      shift_in(1, rd);
      check("R6 snr bits", rd, 32'hA5);
      check("R3 snr held", rd, exp_snr);

      // R9 latch on unused address
      pulse_latch(4'h5);
      check("R9 stat irq kept", irq_stat_n, 0);
      check("R9 snr irq kept", irq_snr_n, 0);

      // R4 selective clear
      pulse_latch(4'h1);
      check("R4 snr cleared", irq_snr_n, 1);
      check("R4 stat untouched", irq_stat_n, 0);
      pulse_latch(4'h0);
      check("R4 stat cleared", irq_stat_n, 1);

      // R8 reset blocks status only
      rst2_n = 0; waitn(2);
      offer_stat(4'h9); waitn(1);
      check("R8 no stat load in reset", irq_stat_n, 1);
      for (int i = 0; i < 128; i++) tick(8'h5A);
      check("R8 snr loads in reset", irq_snr_n, 0);
      shift_in(1, rd);
      check("R8 snr read in reset", rd, 32'h5A);
      pulse_latch(4'h1);
      rst2_n = 1; waitn(2);
      shift_in(0, rd);
      check("R8 stat kept old value", rd, 32'hB);

      // constrained random status traffic
      for (int k = 0; k < 20; k++) begin
         logic [3:0] v1 = 4'($urandom), v2 = 4'($urandom);
         offer_stat(v1); waitn(1);
         check("R2 random irq", irq_stat_n, 0);
         offer_stat(v2);
         shift_in(0, rd);
         check("R3 random held", rd, 32'(exp_stat));
         pulse_latch(4'h0);
         check("R4 random clear", irq_stat_n, 1);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule